// File: doc/BRIEF.md
# Reorder Buffer with Register Rename Lookup

This block tracks in-flight instructions in a small circular buffer. Decode writes one instruction per cycle in program order. Each source operand is resolved at insertion from one of three places. It may come from a result already held by an older in-flight entry. It may come from a tag that names the entry still producing the value. Otherwise it comes from the committed register file, which is held inside the block. Each destination register is then remapped to the new entry's tag. The rename table is a tag cache: each register has one valid bit and one tag.

Entries whose operands are all known are offered to the execution side, and the lowest-indexed eligible entry is picked. Finished results come back tagged and carry a cause code. Each result is broadcast to every entry that is waiting on that tag. The entry at the head of the buffer retires once its result is present. A zero cause writes the committed register file. A non-zero cause raises an exception and clears the whole buffer and the rename table, so that exceptions are precise.

Top module: `rob_core`

## Requirements
- R1: After reset the block accepts insertion and shows no dispatch candidate, no commit and no exception. Every committed register reads as zero.
- R2: Inserted instructions get tags 0, 1, 2 … in order, shown on `ins_tag` before the accepting edge. After NUM_ENTRIES-1 the tag wraps to 0.
- R3: When NUM_ENTRIES instructions are in flight, `ins_ready` is low. An insertion attempted then changes no entry and no tag.
- R4: A source register with no valid rename is ready at insertion and carries the committed register value.
- R5: An entry is offered for dispatch only if it is in use, not yet dispatched, and has both sources ready. Among such entries the lowest tag is offered. Once accepted, the entry is never offered again.
- R6: A source waiting on a tag becomes ready when that tag's result arrives and carries the result data. The entry can be offered in the cycle after the result.
- R7: A source renamed to an entry whose result is already present, or arrives in the same cycle, is ready at insertion with that result.
- R8: Commits follow program order. The head entry shows `cmt_valid` with its destination and data in the cycle after its result with cause 0 arrives. A younger finished entry waits behind an unfinished older one.
- R9: A commit writes its data into the committed register file. A later reader with no rename then sees that value.
- R10: A commit clears a register's rename only if the rename still names the committing tag. A younger writer of the same register keeps later readers waiting on the younger tag.
- R11: A head entry whose result has a non-zero cause shows `exc_valid` with the cause and its tag, and does not commit. On the next cycle the buffer is empty, all renames are gone, and the next tag handed out equals the excepting tag.
- R12: `ins_ready` is low in the cycle in which `exc_valid` is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Instruction offered for insertion |
| ins_op | input | OP_W | Operation code stored with the entry |
| ins_dst | input | REG_W | Destination register |
| ins_src1 | input | REG_W | First source register |
| ins_src2 | input | REG_W | Second source register |
| ins_ready | output | 1 | Insertion accepted this cycle when high |
| ins_tag | output | TAG_W | Tag the next inserted instruction receives |
| disp_valid | output | 1 | An entry is eligible for dispatch |
| disp_tag | output | TAG_W | Tag of the offered entry |
| disp_op | output | OP_W | Operation of the offered entry |
| disp_opnd1 | output | DATA_W | First operand value |
| disp_opnd2 | output | DATA_W | Second operand value |
| disp_accept | input | 1 | Execution side takes the offered entry |
| res_valid | input | 1 | Result returning |
| res_tag | input | TAG_W | Tag the result belongs to |
| res_data | input | DATA_W | Result value |
| res_cause | input | CAUSE_W | Exception cause, 0 for none |
| cmt_valid | output | 1 | Head entry commits this cycle |
| cmt_dst | output | REG_W | Committed destination register |
| cmt_data | output | DATA_W | Committed value |
| exc_valid | output | 1 | Head entry raises an exception this cycle |
| exc_cause | output | CAUSE_W | Cause of the exception |
| exc_tag | output | TAG_W | Tag of the excepting entry |

## Verification
Insertion, dispatch offers and commit outputs are all decoded from registered state. A stimulus driven in one cycle therefore shows its effect exactly one clock edge later. A result changes waiting operands and the head's commit or exception outputs in the next cycle. An exception empties the buffer at the edge that closes the cycle in which it is shown. Inputs are driven just after the falling edge, and every output is sampled a short delay later in the same low phase, before the rising edge that consumes it. Expected commits are queued in program order as instructions are inserted, and a monitor pops one for each cycle that shows `cmt_valid`.

// File: rtl/rob_pkg.sv
package rob_pkg;
    parameter int NUM_ENTRIES = 4;
    parameter int NUM_REGS    = 8;
    parameter int DATA_W      = 16;
    parameter int OP_W        = 4;
    parameter int CAUSE_W     = 3;

    localparam int TAG_W = $clog2(NUM_ENTRIES);
    localparam int REG_W = $clog2(NUM_REGS);
    localparam int CNT_W = TAG_W + 1;

    typedef logic [TAG_W-1:0]   tag_t;
    typedef logic [REG_W-1:0]   reg_t;
    typedef logic [DATA_W-1:0]  data_t;
    typedef logic [CAUSE_W-1:0] cause_t;

    // An operand field holds data once rdy is set, a producer tag in its low bits otherwise
    typedef struct packed {
        logic              in_use;
        logic              exec_b;
        logic [OP_W-1:0]   op;
        logic              rdy1;
        data_t             opnd1;
        logic              rdy2;
        data_t             opnd2;
        logic              done;
        reg_t              dst;
        data_t             data;
        cause_t            cause;
    } rob_entry_t;

    typedef struct packed {
        logic vld;
        tag_t tag;
    } ren_entry_t;

    typedef struct packed {
        rob_entry_t [NUM_ENTRIES-1:0] ent;
        ren_entry_t [NUM_REGS-1:0]    ren;
        data_t      [NUM_REGS-1:0]    arch;
        tag_t                         head;
        tag_t                         alloc;
        logic       [CNT_W-1:0]       count;
    } rob_state_t;

    function automatic tag_t tag_next(input tag_t t);
        return (t == tag_t'(NUM_ENTRIES - 1)) ? '0 : t + 1'b1;
    endfunction
endpackage

// File: rtl/rob_pick.sv
module rob_pick #(
    parameter int N     = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/rob_src_lookup.sv
module rob_src_lookup
    import rob_pkg::*;
(
    input  reg_t                         src_reg,
    input  ren_entry_t [NUM_REGS-1:0]    ren_tbl,
    input  data_t      [NUM_REGS-1:0]    arch,
    input  logic       [NUM_ENTRIES-1:0] done_vec,
    input  data_t      [NUM_ENTRIES-1:0] data_vec,
    input  logic                         res_valid,
    input  tag_t                         res_tag,
    input  data_t                        res_data,
    output logic                         rdy,
    output data_t                        opnd
);
    ren_entry_t map;

    always_comb begin
        map = ren_tbl[src_reg];
        if (!map.vld) begin
            rdy  = 1'b1;
            opnd = arch[src_reg];
        end else if (done_vec[map.tag]) begin
            rdy  = 1'b1;
            opnd = data_vec[map.tag];
        end else if (res_valid && res_tag == map.tag) begin
            rdy  = 1'b1;
            opnd = res_data;
        end else begin
            rdy  = 1'b0;
            opnd = DATA_W'(map.tag);
        end
    end
endmodule

// File: rtl/rob_core.sv
module rob_core
    import rob_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ins_valid,
    input  logic [OP_W-1:0]     ins_op,
    input  logic [REG_W-1:0]    ins_dst,
    input  logic [REG_W-1:0]    ins_src1,
    input  logic [REG_W-1:0]    ins_src2,
    output logic                ins_ready,
    output logic [TAG_W-1:0]    ins_tag,
    output logic                disp_valid,
    output logic [TAG_W-1:0]    disp_tag,
    output logic [OP_W-1:0]     disp_op,
    output logic [DATA_W-1:0]   disp_opnd1,
    output logic [DATA_W-1:0]   disp_opnd2,
    input  logic                disp_accept,
    input  logic                res_valid,
    input  logic [TAG_W-1:0]    res_tag,
    input  logic [DATA_W-1:0]   res_data,
    input  logic [CAUSE_W-1:0]  res_cause,
    output logic                cmt_valid,
    output logic [REG_W-1:0]    cmt_dst,
    output logic [DATA_W-1:0]   cmt_data,
    output logic                exc_valid,
    output logic [CAUSE_W-1:0]  exc_cause,
    output logic [TAG_W-1:0]    exc_tag
);
    rob_state_t st_q, st_d;

    logic [NUM_ENTRIES-1:0] elig;
    logic [NUM_ENTRIES-1:0] done_vec;
    data_t [NUM_ENTRIES-1:0] data_vec;
    logic                   pick_found;
    tag_t                   pick_idx;
    rob_entry_t             head_e;
    rob_entry_t             pick_e;
    reg_t                   src_sel  [2];
    logic                   src_rdy  [2];
    data_t                  src_opnd [2];
    logic                   ins_fire;

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
        assign elig[g]     = st_q.ent[g].in_use & ~st_q.ent[g].exec_b &
                             st_q.ent[g].rdy1 & st_q.ent[g].rdy2;
        assign done_vec[g] = st_q.ent[g].in_use & st_q.ent[g].done;
        assign data_vec[g] = st_q.ent[g].data;
    end

    rob_pick #(.N(NUM_ENTRIES)) pick_i (
        .req   (elig),
        .found (pick_found),
        .idx   (pick_idx)
    );

    assign src_sel[0] = ins_src1;
    assign src_sel[1] = ins_src2;

    for (genvar s = 0; s < 2; s++) begin : g_src
        rob_src_lookup look_i (
            .src_reg   (src_sel[s]),
            .ren_tbl   (st_q.ren),
            .arch      (st_q.arch),
            .done_vec  (done_vec),
            .data_vec  (data_vec),
            .res_valid (res_valid),
            .res_tag   (res_tag),
            .res_data  (res_data),
            .rdy       (src_rdy[s]),
            .opnd      (src_opnd[s])
        );
    end

    assign head_e     = st_q.ent[st_q.head];
    assign pick_e     = st_q.ent[pick_idx];
    assign cmt_valid  = head_e.in_use & head_e.done & (head_e.cause == '0);
    assign exc_valid  = head_e.in_use & head_e.done & (head_e.cause != '0);
    assign cmt_dst    = head_e.dst;
    assign cmt_data   = head_e.data;
    assign exc_cause  = head_e.cause;
    assign exc_tag    = st_q.head;
    assign ins_ready  = (st_q.count != CNT_W'(NUM_ENTRIES)) & ~exc_valid;
    assign ins_tag    = st_q.alloc;
    assign ins_fire   = ins_valid & ins_ready;
    assign disp_valid = pick_found;
    assign disp_tag   = pick_idx;
    assign disp_op    = pick_e.op;
    assign disp_opnd1 = pick_e.opnd1;
    assign disp_opnd2 = pick_e.opnd2;

    always_comb begin
        rob_entry_t new_e;
        st_d  = st_q;
        new_e = '0;
        if (exc_valid) begin
            st_d.ent   = '0;
            st_d.ren   = '0;
            st_d.alloc = st_q.head;
            st_d.count = '0;
        end else begin
            if (disp_valid && disp_accept) begin
                st_d.ent[pick_idx].exec_b = 1'b1;
            end
            if (res_valid) begin
                if (st_q.ent[res_tag].in_use) begin
                    st_d.ent[res_tag].done  = 1'b1;
                    st_d.ent[res_tag].data  = res_data;
                    st_d.ent[res_tag].cause = res_cause;
                end
                for (int i = 0; i < NUM_ENTRIES; i++) begin
                    if (st_q.ent[i].in_use && !st_q.ent[i].rdy1 &&
                        st_q.ent[i].opnd1[TAG_W-1:0] == res_tag) begin
                        st_d.ent[i].rdy1  = 1'b1;
                        st_d.ent[i].opnd1 = res_data;
                    end
                    if (st_q.ent[i].in_use && !st_q.ent[i].rdy2 &&
                        st_q.ent[i].opnd2[TAG_W-1:0] == res_tag) begin
                        st_d.ent[i].rdy2  = 1'b1;
                        st_d.ent[i].opnd2 = res_data;
                    end
                end
            end
            if (cmt_valid) begin
                st_d.arch[head_e.dst]          = head_e.data;
                st_d.ent[st_q.head].in_use     = 1'b0;
                st_d.head                      = tag_next(st_q.head);
                if (st_q.ren[head_e.dst].vld && st_q.ren[head_e.dst].tag == st_q.head) begin
                    st_d.ren[head_e.dst].vld = 1'b0;
                end
            end
            if (ins_fire) begin
                new_e.in_use = 1'b1;
                new_e.op     = ins_op;
                new_e.rdy1   = src_rdy[0];
                new_e.opnd1  = src_opnd[0];
                new_e.rdy2   = src_rdy[1];
                new_e.opnd2  = src_opnd[1];
                new_e.dst    = ins_dst;
                st_d.ent[st_q.alloc] = new_e;
                st_d.ren[ins_dst]    = '{vld: 1'b1, tag: st_q.alloc};
                st_d.alloc           = tag_next(st_q.alloc);
            end
            st_d.count = st_q.count + CNT_W'(ins_fire) - CNT_W'(cmt_valid);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/rob_core_chk.sv
module rob_core_chk
    import rob_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       ins_valid,
    input logic       ins_ready,
    input tag_t       ins_tag,
    input logic       disp_valid,
    input logic       disp_accept,
    input tag_t       disp_tag,
    input logic       cmt_valid,
    input logic       exc_valid,
    input tag_t       exc_tag
);
    logic [CNT_W-1:0] occ_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q <= '0;
        end else if (exc_valid) begin
            occ_q <= '0;
        end else begin
            occ_q <= occ_q + CNT_W'(ins_valid && ins_ready) - CNT_W'(cmt_valid);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        occ_q == CNT_W'(NUM_ENTRIES) |-> !ins_ready); // R3
    AST_ROOM_ACCEPTS: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_q < CNT_W'(NUM_ENTRIES) && !exc_valid) |-> ins_ready); // R3
    AST_TAG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && ins_ready) |=> ins_tag == tag_next($past(ins_tag))); // R2
    AST_TAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!(ins_valid && ins_ready) && !exc_valid) |=> $stable(ins_tag)); // R3
    AST_DISP_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && disp_accept) |=> !(disp_valid && disp_tag == $past(disp_tag))); // R5
    AST_CMT_EXC_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmt_valid && exc_valid)); // R11
    AST_EXC_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> !ins_ready); // R12
    AST_EXC_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |=> (!disp_valid && !cmt_valid && !exc_valid && ins_ready)); // R11
    AST_EXC_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |=> ins_tag == $past(exc_tag)); // R11
endmodule

bind rob_core rob_core_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ins_valid   (ins_valid),
    .ins_ready   (ins_ready),
    .ins_tag     (ins_tag),
    .disp_valid  (disp_valid),
    .disp_accept (disp_accept),
    .disp_tag    (disp_tag),
    .cmt_valid   (cmt_valid),
    .exc_valid   (exc_valid),
    .exc_tag     (exc_tag)
);

// File: tb/rob_core_tb_top.sv
module rob_core_tb_top;
    import rob_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ins_valid, disp_accept, res_valid;
    logic [OP_W-1:0] ins_op;
    reg_t ins_dst, ins_src1, ins_src2;
    tag_t res_tag;
    data_t res_data;
    cause_t res_cause;
    logic ins_ready, disp_valid, cmt_valid, exc_valid;
    tag_t ins_tag, disp_tag, exc_tag;
    logic [OP_W-1:0] disp_op;
    data_t disp_opnd1, disp_opnd2, cmt_data;
    reg_t cmt_dst;
    cause_t exc_cause;

    int n_checks = 0;
    int n_fail = 0;
    int exp_tag = 0;
    logic [REG_W+DATA_W-1:0] exp_q[$];

    always #10 clk = ~clk;

    rob_core dut_i (
        .clk(clk), .rst_n(rst_n),
        .ins_valid(ins_valid), .ins_op(ins_op), .ins_dst(ins_dst),
        .ins_src1(ins_src1), .ins_src2(ins_src2),
        .ins_ready(ins_ready), .ins_tag(ins_tag),
        .disp_valid(disp_valid), .disp_tag(disp_tag), .disp_op(disp_op),
        .disp_opnd1(disp_opnd1), .disp_opnd2(disp_opnd2), .disp_accept(disp_accept),
        .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data), .res_cause(res_cause),
        .cmt_valid(cmt_valid), .cmt_dst(cmt_dst), .cmt_data(cmt_data),
        .exc_valid(exc_valid), .exc_cause(exc_cause), .exc_tag(exc_tag)
    );

    task automatic chk_eq(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic quiet();
        ins_valid = 0; ins_op = '0; ins_dst = '0; ins_src1 = '0; ins_src2 = '0;
        disp_accept = 0; res_valid = 0; res_tag = '0; res_data = '0; res_cause = '0;
    endtask

    // Scoreboard driver: pushes the expected commit when the instruction enters
    task automatic insert(input int dst, input int s1, input int s2, input bit push,
                          input int pdata, input string req);
        @(negedge clk);
        quiet();
        ins_valid = 1; ins_op = OP_W'(dst + 1); ins_dst = reg_t'(dst);
        ins_src1 = reg_t'(s1); ins_src2 = reg_t'(s2);
        #2;
        chk_eq(req, "ins_ready", int'(ins_ready), 1);
        chk_eq("R2", "ins_tag", int'(ins_tag), exp_tag);
        if (push) exp_q.push_back({reg_t'(dst), data_t'(pdata)});
        exp_tag = (exp_tag + 1) % NUM_ENTRIES;
    endtask

    task automatic dispatch(input int tag, input int v1, input int v2, input bit acc,
                            input string req);
        @(negedge clk);
        quiet();
        disp_accept = acc;
        #2;
        chk_eq(req, "disp_valid", int'(disp_valid), 1);
        chk_eq(req, "disp_tag", int'(disp_tag), tag);
        chk_eq(req, "disp_opnd1", int'(disp_opnd1), v1);
        chk_eq(req, "disp_opnd2", int'(disp_opnd2), v2);
    endtask

    task automatic result(input int tag, input int data, input int cause);
        @(negedge clk);
        quiet();
        res_valid = 1; res_tag = tag_t'(tag); res_data = data_t'(data); res_cause = cause_t'(cause);
        #2;
    endtask

    task automatic no_disp(input string req);
        @(negedge clk);
        quiet();
        #2;
        chk_eq(req, "disp_valid", int'(disp_valid), 0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            quiet();
        end
    endtask

    // Scoreboard monitor: one expected item per committing cycle
    always @(negedge clk) begin
        #2;
        if (rst_n && cmt_valid) begin
            if (exp_q.size() == 0) begin
                chk_eq("R8", "unexpected commit dst", int'(cmt_dst), -1);
            end else begin
                logic [REG_W+DATA_W-1:0] e;
                e = exp_q.pop_front();
                chk_eq("R8", "cmt_dst", int'(cmt_dst), int'(e[REG_W+DATA_W-1:DATA_W]));
                chk_eq("R9", "cmt_data", int'(cmt_data), int'(e[DATA_W-1:0]));
            end
        end
    end

    bit done = 0;

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            chk_eq("WDOG", "watchdog expired", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        quiet();
        repeat (3) @(negedge clk);
        rst_n = 1;
        #2;
        chk_eq("R1", "ins_ready", int'(ins_ready), 1);
        chk_eq("R1", "disp_valid", int'(disp_valid), 0);
        chk_eq("R1", "cmt_valid", int'(cmt_valid), 0);
        chk_eq("R1", "exc_valid", int'(exc_valid), 0);

        // Wake-up and in-order commit
        insert(1, 2, 3, 1, 'h11, "R4");
        insert(4, 1, 0, 1, 'h22, "R6");
        dispatch(0, 0, 0, 1, "R4");
        no_disp("R5");
        result(0, 'h11, 0);
        dispatch(1, 'h11, 0, 1, "R6");
        result(1, 'h22, 0);
        idle(1);
        insert(5, 1, 4, 1, 'h44, "R9");
        insert(6, 0, 0, 1, 'h33, "R2");
        dispatch(2, 'h11, 'h22, 1, "R9");
        dispatch(3, 0, 0, 1, "R5");
        result(3, 'h33, 0);
        @(negedge clk); quiet(); #2;
        chk_eq("R8", "younger waits, cmt_valid", int'(cmt_valid), 0);
        result(2, 'h44, 0);
        idle(3);

        // Present-result lookup, full buffer, conditional rename clear
        insert(7, 0, 0, 1, 'h66, "R2");
        insert(2, 0, 0, 1, 'h55, "R2");
        dispatch(0, 0, 0, 1, "R5");
        dispatch(1, 0, 0, 1, "R5");
        result(1, 'h55, 0);
        insert(3, 2, 7, 1, 'h88, "R7");
        insert(2, 0, 0, 1, 'h77, "R10");
        @(negedge clk); quiet();
        ins_valid = 1; ins_dst = reg_t'(0);
        #2;
        chk_eq("R3", "ins_ready when full", int'(ins_ready), 0);
        dispatch(3, 0, 0, 0, "R3");
        chk_eq("R3", "ins_tag held", int'(ins_tag), 0);
        result(0, 'h66, 0);
        dispatch(2, 'h55, 'h66, 1, "R7");
        insert(1, 2, 0, 1, 'h99, "R10");
        dispatch(3, 0, 0, 1, "R10");
        no_disp("R10");
        result(3, 'h77, 0);
        dispatch(0, 'h77, 0, 1, "R10");
        result(2, 'h88, 0);
        result(0, 'h99, 0);
        idle(4);

        // Exception and flush
        insert(5, 0, 0, 0, 0, "R11");
        insert(6, 5, 0, 0, 0, "R11");
        insert(4, 0, 0, 0, 0, "R11");
        dispatch(1, 0, 0, 1, "R5");
        result(1, 'hAA, 3);
        @(negedge clk); quiet(); #2;
        chk_eq("R11", "exc_valid", int'(exc_valid), 1);
        chk_eq("R11", "exc_cause", int'(exc_cause), 3);
        chk_eq("R11", "exc_tag", int'(exc_tag), 1);
        chk_eq("R11", "cmt_valid", int'(cmt_valid), 0);
        chk_eq("R12", "ins_ready during exception", int'(ins_ready), 0);
        @(negedge clk); quiet(); #2;
        chk_eq("R11", "exc_valid after flush", int'(exc_valid), 0);
        chk_eq("R11", "disp_valid after flush", int'(disp_valid), 0);
        chk_eq("R11", "ins_ready after flush", int'(ins_ready), 1);
        chk_eq("R11", "ins_tag after flush", int'(ins_tag), 1);
        exp_tag = 1;
        insert(7, 5, 6, 1, 'hBB, "R11");
        dispatch(1, 'h44, 'h33, 1, "R11");
        result(1, 'hBB, 0);
        idle(4);
        chk_eq("R8", "pending commits", exp_q.size(), 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule